// File: doc/BRIEF.md
# Single-Wire Debug Bit Transmitter

This block sits on the target side of a single-wire, open-drain debug link and returns one data bit for each bit slot that the external host opens. The host opens a slot by pulling the shared line low. The block passes the line through a synchronizer into its own debug clock domain and detects the falling edge there. It then answers in one of two ways. For a one, it leaves the line released and, seven cycles into the slot, drives a single-cycle active-high speed-up pulse. For a zero, it pulls the line low for thirteen cycles and then drives the same single-cycle speed-up pulse. The pulse sharpens the rising edge of the line, which would otherwise rise slowly through its pull-up.

The bit to send is handed over through a valid/ready pair and is held until a slot consumes it. If a slot opens and no bit is waiting, the block answers with a one. Once a slot has opened, further falling edges are ignored until that slot has finished and the line has been seen high again. A one-cycle done strobe marks the end of every slot. The line is taken as an asynchronous input, so the host has to keep its own low drive until the target's low drive has begun. That takes four debug-clock cycles with the default synchronizer depth.

Top module: `swdbg_bit_tx`

## Requirements
- R1: After reset, driveLow, driveHigh and slotDone are 0 and loadReady is 1.
- R2: The first rising clock edge that samples lineIn low is edge E1. The perceived slot start is edge P = E1 + 3: two edges for the synchronizer, one for edge detection and one for the registered drive outputs.
- R3: For a zero, driveLow is 1 in exactly the 13 cycles that follow edges P through P+12, and is 0 otherwise during the slot.
- R4: For a zero, driveHigh is 1 for exactly one cycle, the one that follows edge P+13.
- R5: For a one, driveLow stays 0 for the whole slot, and driveHigh is 1 for exactly one cycle, the one that follows edge P+7.
- R6: driveLow and driveHigh are never 1 in the same cycle.
- R7: slotDone is 1 for exactly one cycle per slot, and that cycle is the one in which driveHigh carries the speed-up pulse.
- R8: loadReady is 1 exactly when no bit is pending. A cycle with loadValid=1 and loadReady=1 captures loadBit (1 = send a one, 0 = send a zero), and loadReady then stays 0 until a slot start consumes the bit. A loadValid while loadReady is 0 is ignored.
- R9: A slot that opens while no bit is pending is answered as a one (R5 timing), and loadReady stays 1.
- R10: A falling edge on lineIn after a slot has started and before the slot has finished neither opens a second slot nor consumes a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock |
| rstN | input | 1 | Active-low asynchronous reset |
| loadValid | input | 1 | A bit is offered for the next slot |
| loadBit | input | 1 | Value of the offered bit |
| loadReady | output | 1 | No bit pending; an offer is accepted this cycle |
| lineIn | input | 1 | Level of the shared debug line (asynchronous) |
| driveLow | output | 1 | Enable for the pad's pull-down driver |
| driveHigh | output | 1 | Enable for the pad's speed-up pull-up driver |
| slotDone | output | 1 | One-cycle strobe at the end of each slot |

## Verification
Each result is due a fixed number of edges after the edge where the bench's host drive first reaches the block. The response begins three edges later. A zero holds the low drive for 13 cycles and pulses at offset 13. A one pulses at offset 7. The done strobe coincides with the pulse. The driver task notes the cycle number when it pulls the line low and queues the expected bit together with the derived start cycle. The monitor samples on the falling clock edge and compares the first and last low-drive cycles, the pulse cycle and the strobe cycle against those offsets. A stray pulse or strobe with nothing queued is reported as a failure, which covers the ignored second edge.

// File: rtl/dbgtx_pkg.sv
package dbgtx_pkg;

  // Strobes from the slot sequencer to the datapath, valid for one cycle
  typedef struct packed {
    logic startSlot;   // slot opens: latch the bit to send
    logic holdLow;     // pull the line low next cycle
    logic pulseHigh;   // speed-up pulse next cycle
    logic finish;      // slot completes next cycle
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_SLOT     = 2'd1,
    ST_WAITHIGH = 2'd2
  } txState_t;

endpackage

// File: rtl/dbgtx_datapath.sv
module dbgtx_datapath
  import dbgtx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineIn,
  input  logic       loadValid,
  input  logic       loadBit,
  input  ctlStrobe_t strobe,
  output logic       lineFall,
  output logic       lineHigh,
  output logic       slotBit,
  output logic       loadReady,
  output logic       driveLow,
  output logic       driveHigh,
  output logic       slotDone
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  // Synchronizer chain; idle level of the line is high
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevLine;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : gSync
      if (i == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[i] <= 1'b1;
          else       syncQ[i] <= lineIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[i] <= 1'b1;
          else       syncQ[i] <= syncQ[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLine <= 1'b1;
    else       prevLine <= syncQ[LAST_STAGE];
  end

  assign lineHigh = syncQ[LAST_STAGE];
  assign lineFall = prevLine & ~syncQ[LAST_STAGE];

  // Pending-bit holder with valid/ready handshake
  logic hasBit;
  logic pendBit;
  logic acceptLoad;

  assign loadReady  = ~hasBit;
  assign acceptLoad = loadValid & ~hasBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hasBit  <= 1'b0;
      pendBit <= 1'b1;
    end else if (strobe.startSlot && hasBit) begin
      hasBit  <= 1'b0;
    end else if (acceptLoad) begin
      hasBit  <= 1'b1;
      pendBit <= loadBit;
    end
  end

  // Bit in flight for the current slot; a one when nothing was pending
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 slotBit <= 1'b1;
    else if (strobe.startSlot) slotBit <= hasBit ? pendBit : 1'b1;
  end

  // Registered pad enables, glitch-free towards the pad
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      driveLow  <= 1'b0;
      driveHigh <= 1'b0;
      slotDone  <= 1'b0;
    end else begin
      driveLow  <= strobe.holdLow & ~strobe.pulseHigh;
      driveHigh <= strobe.pulseHigh;
      slotDone  <= strobe.finish;
    end
  end

  // R6
  noBothDrive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(driveLow && driveHigh));

  // R4
  pulseOneCycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveHigh |=> !driveHigh);

  // R7
  pulseWithDone_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveHigh |-> slotDone);

  // R3
  lowEndsInPulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(driveLow) |-> driveHigh);

  // R8
  loadHold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && loadReady) |=> !loadReady);

endmodule

// File: rtl/dbgtx_control.sv
module dbgtx_control
  import dbgtx_pkg::*;
#(
  parameter int ONE_PULSE_AT = 7,
  parameter int ZERO_LOW_LEN = 13
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineFall,
  input  logic       lineHigh,
  input  logic       slotBit,
  output ctlStrobe_t strobe
);

  localparam int LAST_AT = (ONE_PULSE_AT > ZERO_LOW_LEN) ? ONE_PULSE_AT : ZERO_LOW_LEN;
  localparam int CNT_W   = $clog2(LAST_AT + 1);
  localparam logic [CNT_W-1:0] ONE_AT_C  = CNT_W'(ONE_PULSE_AT);
  localparam logic [CNT_W-1:0] ZERO_AT_C = CNT_W'(ZERO_LOW_LEN);

  txState_t         state;
  logic [CNT_W-1:0] cnt;
  logic             atPulse;

  assign atPulse = (cnt == (slotBit ? ONE_AT_C : ZERO_AT_C));

  always_comb begin
    strobe = '0;
    unique case (state)
      ST_IDLE: begin
        strobe.startSlot = lineFall;
      end
      ST_SLOT: begin
        strobe.holdLow   = ~slotBit & (cnt < ZERO_AT_C);
        strobe.pulseHigh = atPulse;
        strobe.finish    = atPulse;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (lineFall) state <= ST_SLOT;
        end
        ST_SLOT: begin
          if (atPulse) state <= ST_WAITHIGH;
          else         cnt   <= cnt + 1'b1;
        end
        ST_WAITHIGH: begin
          if (lineHigh) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  slotBound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SLOT) |-> (cnt <= ZERO_AT_C || cnt <= ONE_AT_C));

  // R2
  idleHolds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !lineFall) |=> (state == ST_IDLE));

endmodule

// File: rtl/swdbg_bit_tx.sv
module swdbg_bit_tx
  import dbgtx_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int ONE_PULSE_AT = 7,
  parameter int ZERO_LOW_LEN = 13
) (
  input  logic clk,
  input  logic rstN,
  input  logic loadValid,
  input  logic loadBit,
  output logic loadReady,
  input  logic lineIn,
  output logic driveLow,
  output logic driveHigh,
  output logic slotDone
);

  ctlStrobe_t strobe;
  logic       lineFall;
  logic       lineHigh;
  logic       slotBit;

  dbgtx_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .lineIn    (lineIn),
    .loadValid (loadValid),
    .loadBit   (loadBit),
    .strobe    (strobe),
    .lineFall  (lineFall),
    .lineHigh  (lineHigh),
    .slotBit   (slotBit),
    .loadReady (loadReady),
    .driveLow  (driveLow),
    .driveHigh (driveHigh),
    .slotDone  (slotDone)
  );

  dbgtx_control #(
    .ONE_PULSE_AT(ONE_PULSE_AT),
    .ZERO_LOW_LEN(ZERO_LOW_LEN)
  ) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .lineFall (lineFall),
    .lineHigh (lineHigh),
    .slotBit  (slotBit),
    .strobe   (strobe)
  );

endmodule

// File: tb/swdbg_bit_tx_bench.sv
`timescale 1ns/1ps
module swdbg_bit_tx_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadValid = 1'b0;
  logic loadBit = 1'b0;
  logic loadReady;
  logic hostLow = 1'b0;
  logic lineIn;
  logic driveLow, driveHigh, slotDone;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  int expBitQ[$];
  int expStartQ[$];

  always #2.5 clk = ~clk;

  // Wired line: low if the host or the target pulls it low
  assign lineIn = ~(hostLow | driveLow);

  swdbg_bit_tx u_swdbg_bit_tx (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadBit(loadBit),
    .loadReady(loadReady), .lineIn(lineIn), .driveLow(driveLow),
    .driveHigh(driveHigh), .slotDone(slotDone)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Driver: offer a bit through the handshake
  task automatic offerBit(input bit b, input bit expectTaken);
    @(negedge clk);
    loadValid = 1'b1;
    loadBit   = b;
    @(negedge clk);
    loadValid = 1'b0;
    if (expectTaken) check(loadReady == 1'b0, "R8 ready drops after capture", loadReady, 0);
  endtask

  // Driver: host opens a slot; queues the expected result
  task automatic hostSlot(input bit expBit);
    @(negedge clk);
    expBitQ.push_back(expBit);
    expStartQ.push_back(cyc + 4);
    hostLow = 1'b1;
    repeat (4) @(negedge clk);
    hostLow = 1'b0;
  endtask

  // Monitor / scoreboard
  int lowCount = 0, lowFirst = 0, lowLast = 0;
  logic prevDh = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (driveLow || driveHigh)
        check(!(driveLow && driveHigh), "R6 both drives", 1, 0);
      if (driveHigh || slotDone)
        check(driveHigh == slotDone, "R7 done with pulse", slotDone, driveHigh);
      if (driveHigh)
        check(!prevDh, "R4 pulse one cycle", prevDh, 0);
      if (driveLow) begin
        if (lowCount == 0) lowFirst = cyc;
        lowLast = cyc;
        lowCount++;
      end
      if (slotDone) begin
        if (expBitQ.size() == 0) begin
          check(1'b0, "R10 unexpected slot", 1, 0);
        end else begin
          int b, p;
          b = expBitQ.pop_front();
          p = expStartQ.pop_front();
          if (b != 0) begin
            check(cyc == p + 7, "R5 one pulse cycle", cyc, p + 7);
            check(lowCount == 0, "R5 one no low drive", lowCount, 0);
          end else begin
            check(cyc == p + 13, "R4 zero pulse cycle", cyc, p + 13);
            check(lowCount == 13, "R3 zero low length", lowCount, 13);
            check(lowFirst == p, "R2 zero low start", lowFirst, p);
            check(lowLast == p + 12, "R3 zero low end", lowLast, p + 12);
          end
        end
        lowCount = 0;
      end
      prevDh = driveHigh;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(driveLow == 1'b0,  "R1 driveLow reset",  driveLow, 0);
    check(driveHigh == 1'b0, "R1 driveHigh reset", driveHigh, 0);
    check(slotDone == 1'b0,  "R1 slotDone reset",  slotDone, 0);
    check(loadReady == 1'b1, "R1 loadReady reset", loadReady, 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R3/R4 zero slot
    offerBit(1'b0, 1'b1);
    hostSlot(1'b0);
    repeat (30) @(negedge clk);
    check(loadReady == 1'b1, "R8 ready after consume", loadReady, 1);

    // R5 one slot
    offerBit(1'b1, 1'b1);
    hostSlot(1'b1);
    repeat (30) @(negedge clk);

    // R9 nothing loaded: answered as one
    hostSlot(1'b1);
    repeat (30) @(negedge clk);
    check(loadReady == 1'b1, "R9 ready stays high", loadReady, 1);

    // R8 offer while not ready is ignored: zero stays, one dropped
    offerBit(1'b0, 1'b1);
    offerBit(1'b1, 1'b0);
    check(loadReady == 1'b0, "R8 still pending", loadReady, 0);
    hostSlot(1'b0);
    repeat (30) @(negedge clk);

    // R10 second fall mid-slot is ignored and does not consume a pending bit
    hostSlot(1'b1);
    offerBit(1'b0, 1'b1);
    hostLow = 1'b1;
    repeat (2) @(negedge clk);
    hostLow = 1'b0;
    repeat (30) @(negedge clk);
    check(loadReady == 1'b0, "R10 pending bit kept", loadReady, 0);
    hostSlot(1'b0);
    repeat (30) @(negedge clk);

    // Back-to-back zero then one
    offerBit(1'b0, 1'b1);
    hostSlot(1'b0);
    repeat (20) @(negedge clk);
    offerBit(1'b1, 1'b1);
    hostSlot(1'b1);
    repeat (30) @(negedge clk);

    check(expBitQ.size() == 0, "R7 every slot completed", expBitQ.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule